// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This unit executes the stack-related instructions of a 20-bit accumulator machine whose addresses are 13 bits wide. There are six of them: push, pop, call, return, load stack pointer and store stack pointer. It owns the stack pointer, the memory address register and the memory buffer register. It steps through a short fixed sequence of phases for each instruction and raises memory read or write strobes. At the end of the sequence it asks the surrounding core to write the accumulator or the program counter.

The stack grows upward. A push first increments the pointer and then stores, so the pointer always names the top entry. A pop reads the top entry and then decrements the pointer. A call keeps the upper seven bits of the buffer register and replaces only its low 13 bits with the return address. A return loads the program counter from the popped word and signals the core to go straight back to instruction fetch.

The core raises `start` for one cycle together with a 3-bit operation code. Phase 0 of the instruction takes effect on that clock edge. The remaining phases follow on later cycles while `busy` is high. The accumulator, program counter and operand address inputs must stay stable while the unit is busy. Memory is read combinationally: `mem_rdata` must reflect `mem_addr` within the read cycle.

Top module: `stk_unit`

## Requirements
- R1: After reset the stack pointer and buffer register are zero, `busy` and `done` are low, and no memory strobe is active.
- R2: Push (code 0) increments SP and copies the accumulator into BR, then loads the address register from SP, then writes BR to memory at that address.
- R3: Pop (code 1) loads the address register from SP, reads memory into BR, then writes BR to the accumulator and decrements SP.
- R4: Call (code 2) increments SP, then loads the address register from SP and replaces BR[12:0] with the program counter while keeping BR[19:13], then writes BR to memory and loads the program counter with the operand address.
- R5: Return (code 3) reads the word at SP, loads the program counter with its low 13 bits, decrements SP and pulses `ret_fetch` together with `done`.
- R6: Load-stack-pointer (code 4) reads memory at the operand address and places only bits [12:0] of that word into SP.
- R7: Store-stack-pointer (code 5) replaces only BR[12:0] with SP, keeps BR[19:13], and writes BR to memory at the operand address.
- R8: SP wraps modulo 8192: incrementing 8191 gives 0, and decrementing 0 gives 8191.
- R9: `done` is high for exactly one cycle, in the last phase. That phase comes two cycles after the start cycle for codes 0 to 4, and one cycle after it for code 5.
- R10: `start` is ignored while `busy` is high, including the `done` cycle, and codes 6 and 7 never launch an instruction.
- R11: Memory read and write strobes are never active together, and no strobe or register write request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch request, sampled only when idle |
| op | input | 3 | Operation code (0 push, 1 pop, 2 call, 3 return, 4 load SP, 5 store SP) |
| a_in | input | 20 | Accumulator value from the core |
| pc_in | input | 13 | Program counter value from the core |
| ir_addr | input | 13 | Operand address field of the current instruction |
| mem_rdata | input | 20 | Memory read data for `mem_addr` |
| mem_addr | output | 13 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 20 | Memory write data (buffer register) |
| sp | output | 13 | Stack pointer |
| br | output | 20 | Buffer register |
| a_we | output | 1 | Accumulator write request |
| a_wdata | output | 20 | Accumulator write value |
| pc_we | output | 1 | Program counter write request |
| pc_wdata | output | 13 | Program counter write value |
| busy | output | 1 | An instruction is past its first phase |
| done | output | 1 | Last phase of the current instruction |
| ret_fetch | output | 1 | Return completed; the core must re-enter fetch |

## Verification
Two functions can meet in one cycle: a new launch request, and the final phase of the instruction in flight, which raises `done` and writes memory or the program counter. The bench provokes this by holding `start` high through every phase, including the `done` cycle, while it scrambles the operation code. It then checks that the instruction's length in cycles, the stack pointer, the buffer register, memory and the core registers all match the unprovoked model, and that `busy` drops in the cycle after `done`. In a call, incrementing the pointer and using it in the next phase, with the program counter merged into the buffer register's low bits, is checked through the word that lands in memory.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LDSP = 3'd4,
    OP_STSP = 3'd5
  } stk_op_e;

  localparam int PH_W = 2;

  // Per-cycle micro-actions decoded from (operation, phase)
  typedef struct packed {
    logic sp_inc;
    logic sp_dec;
    logic sp_ld;
    logic ar_sp;
    logic ar_ir;
    logic br_a;
    logic br_pc;
    logic br_sp;
    logic br_mem;
    logic mem_rd;
    logic mem_wr;
    logic a_we;
    logic pc_we;
    logic pc_from_ir;
    logic done;
    logic to_fetch;
  } stk_act_t;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output stk_act_t   act_o
);

  logic            busy_q, busy_n;
  stk_op_e         op_q, op_n;
  logic [PH_W-1:0] ph_q, ph_n;

  logic            launch, adv;
  stk_op_e         cur_op;
  logic [PH_W-1:0] cur_ph, last_ph;

  always_comb begin
    launch  = !busy_q && start && op_known(op_i);
    adv     = launch || busy_q;
    cur_op  = busy_q ? op_q : stk_op_e'(op_i);
    cur_ph  = busy_q ? ph_q : '0;
    last_ph = (cur_op == OP_STSP) ? PH_W'(1) : PH_W'(2);
  end

  // Action decode
  always_comb begin
    act_o = '0;
    if (adv) begin
      unique case (cur_op)
        OP_PUSH: unique case (cur_ph)
          2'd0:    begin act_o.sp_inc = 1'b1; act_o.br_a = 1'b1; end
          2'd1:    act_o.ar_sp = 1'b1;
          default: act_o.mem_wr = 1'b1;
        endcase
        OP_POP: unique case (cur_ph)
          2'd0:    act_o.ar_sp = 1'b1;
          2'd1:    begin act_o.mem_rd = 1'b1; act_o.br_mem = 1'b1; end
          default: begin act_o.a_we = 1'b1; act_o.sp_dec = 1'b1; end
        endcase
        OP_CALL: unique case (cur_ph)
          2'd0:    act_o.sp_inc = 1'b1;
          2'd1:    begin act_o.ar_sp = 1'b1; act_o.br_pc = 1'b1; end
          default: begin act_o.mem_wr = 1'b1; act_o.pc_we = 1'b1; act_o.pc_from_ir = 1'b1; end
        endcase
        OP_RET: unique case (cur_ph)
          2'd0:    act_o.ar_sp = 1'b1;
          2'd1:    begin act_o.mem_rd = 1'b1; act_o.br_mem = 1'b1; end
          default: begin act_o.pc_we = 1'b1; act_o.sp_dec = 1'b1; end
        endcase
        OP_LDSP: unique case (cur_ph)
          2'd0:    act_o.ar_ir = 1'b1;
          2'd1:    begin act_o.mem_rd = 1'b1; act_o.br_mem = 1'b1; end
          default: act_o.sp_ld = 1'b1;
        endcase
        default: unique case (cur_ph)
          2'd0:    begin act_o.ar_ir = 1'b1; act_o.br_sp = 1'b1; end
          default: act_o.mem_wr = 1'b1;
        endcase
      endcase
      act_o.done     = busy_q && (cur_ph == last_ph);
      act_o.to_fetch = act_o.done && (cur_op == OP_RET);
    end
  end

  // Next state
  always_comb begin
    busy_n = busy_q;
    op_n   = op_q;
    ph_n   = ph_q;
    if (launch) begin
      busy_n = 1'b1;
      op_n   = cur_op;
      ph_n   = PH_W'(1);
    end else if (busy_q) begin
      if (ph_q == last_ph) begin
        busy_n = 1'b0;
        ph_n   = '0;
      end else begin
        ph_n   = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_PUSH;
      ph_q   <= '0;
    end else if (adv) begin
      busy_q <= busy_n;
      op_q   <= op_n;
      ph_q   <= ph_n;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_act_t          act,
  input  logic [DATA_W-1:0] a_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ir_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [DATA_W-1:0] br_o
);

  localparam int HI_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] sp_q, sp_n, ar_q, ar_n;
  logic [DATA_W-1:0] br_q, br_n;
  logic              sp_en, ar_en, br_en;
  logic [HI_W-1:0]   br_hi;

  assign br_hi = br_q[DATA_W-1:ADDR_W];

  always_comb begin
    sp_en = act.sp_inc | act.sp_dec | act.sp_ld;
    unique case (1'b1)
      act.sp_inc: sp_n = sp_q + ADDR_W'(1);
      act.sp_dec: sp_n = sp_q - ADDR_W'(1);
      default:    sp_n = br_q[ADDR_W-1:0];
    endcase

    ar_en = act.ar_sp | act.ar_ir;
    ar_n  = act.ar_ir ? ir_i : sp_q;

    br_en = act.br_a | act.br_pc | act.br_sp | act.br_mem;
    unique case (1'b1)
      act.br_a:  br_n = a_i;
      act.br_pc: br_n = {br_hi, pc_i};
      act.br_sp: br_n = {br_hi, sp_q};
      default:   br_n = rdata_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      ar_q <= '0;
      br_q <= '0;
    end else begin
      if (sp_en) sp_q <= sp_n;
      if (ar_en) ar_q <= ar_n;
      if (br_en) br_q <= br_n;
    end
  end

  assign sp_o = sp_q;
  assign ar_o = ar_q;
  assign br_o = br_q;

endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] ir_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] br,
  output logic              a_we,
  output logic [DATA_W-1:0] a_wdata,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wdata,
  output logic              busy,
  output logic              done,
  output logic              ret_fetch
);

  logic     rst_int_n;
  stk_act_t act;

  stk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  stk_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .op_i   (op),
    .busy_o (busy),
    .act_o  (act)
  );

  stk_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .act     (act),
    .a_i     (a_in),
    .pc_i    (pc_in),
    .ir_i    (ir_addr),
    .rdata_i (mem_rdata),
    .sp_o    (sp),
    .ar_o    (mem_addr),
    .br_o    (br)
  );

  assign mem_rd    = act.mem_rd;
  assign mem_wr    = act.mem_wr;
  assign mem_wdata = br;
  assign a_we      = act.a_we;
  assign a_wdata   = br;
  assign pc_we     = act.pc_we;
  assign pc_wdata  = act.pc_from_ir ? ir_addr : br[ADDR_W-1:0];
  assign done      = act.done;
  assign ret_fetch = act.to_fetch;

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] sp,
  input logic [DATA_W-1:0] br,
  input logic              a_we,
  input logic              pc_we,
  input logic              busy,
  input logic              done,
  input logic              ret_fetch
);

  p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr || a_we || pc_we || done));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_fetch_with_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fetch |-> (done && pc_we));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sp) && $stable(br)));

  p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> (sp == ADDR_W'($past(sp) - ADDR_W'(1))));

endmodule

bind stk_unit stk_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .sp        (sp),
  .br        (br),
  .a_we      (a_we),
  .pc_we     (pc_we),
  .busy      (busy),
  .done      (done),
  .ret_fetch (ret_fetch)
);

// File: tb/stk_unit_tb.sv
module stk_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [19:0] a_reg = '0;
  logic [12:0] pc_reg = '0;
  logic [12:0] ir_addr = '0;
  logic [19:0] mem_rdata = '0;
  logic [12:0] mem_addr, sp, pc_wdata;
  logic        mem_rd, mem_wr, a_we, pc_we, busy, done, ret_fetch;
  logic [19:0] mem_wdata, br, a_wdata;

  logic [19:0] mem_m [int];
  logic [12:0] m_sp = '0;
  logic [19:0] m_br = '0;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .a_in(a_reg), .pc_in(pc_reg), .ir_addr(ir_addr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .sp(sp), .br(br), .a_we(a_we), .a_wdata(a_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .busy(busy), .done(done), .ret_fetch(ret_fetch)
  );

  function automatic logic [19:0] rd(input logic [12:0] addr);
    return mem_m.exists(int'(addr)) ? mem_m[int'(addr)] : 20'd0;
  endfunction

  // Environment: memory and core registers, acting on the pending edge
  always @(negedge clk) begin
    if (mem_wr) mem_m[int'(mem_addr)] = mem_wdata;
    if (a_we)   a_reg = a_wdata;
    if (pc_we)  pc_reg = pc_wdata;
    mem_rdata = rd(mem_addr);
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic run_op(input logic [2:0] code, input bit poke);
    logic [12:0] e_sp, e_pc, e_addr;
    logic [19:0] e_br, e_a, e_val;
    bit e_wr, e_fetch, seen_fetch;
    int e_len, cnt;
    string req;
    e_sp = m_sp; e_br = m_br; e_a = a_reg; e_pc = pc_reg;
    e_wr = 0; e_fetch = 0; e_len = 2; e_addr = '0; e_val = '0;
    case (code)
      3'd0: begin req = "R2"; e_sp = m_sp + 13'd1; e_br = a_reg;
                  e_wr = 1; e_addr = e_sp; e_val = a_reg; end
      3'd1: begin req = "R3"; e_br = rd(m_sp); e_a = e_br; e_sp = m_sp - 13'd1; end
      3'd2: begin req = "R4"; e_sp = m_sp + 13'd1; e_br = {m_br[19:13], pc_reg};
                  e_wr = 1; e_addr = e_sp; e_val = e_br; e_pc = ir_addr; end
      3'd3: begin req = "R5"; e_br = rd(m_sp); e_pc = e_br[12:0];
                  e_sp = m_sp - 13'd1; e_fetch = 1; end
      3'd4: begin req = "R6"; e_br = rd(ir_addr); e_sp = e_br[12:0]; end
      default: begin req = "R7"; e_br = {m_br[19:13], m_sp};
                  e_wr = 1; e_addr = ir_addr; e_val = e_br; e_len = 1; end
    endcase
    @(negedge clk);
    op = code;
    start = 1'b1;
    cnt = 0;
    seen_fetch = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (!poke) start = 1'b0;
      else       op = 3'($urandom);
      if (ret_fetch) seen_fetch = 1;
      if (done || cnt > 8) break;
    end
    start = 1'b0;
    @(negedge clk);
    #1;
    chk("R9", "phase count", cnt, e_len);
    chk("R10", "busy after done", busy, 0);
    chk(req, "sp", sp, e_sp);
    chk(req, "br", br, e_br);
    chk(req, "a", a_reg, e_a);
    chk(req, "pc", pc_reg, e_pc);
    chk("R5", "fetch pulse", seen_fetch, e_fetch);
    if (e_wr) chk(req, "mem", rd(e_addr), e_val);
    m_sp = e_sp;
    m_br = e_br;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL R9 watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "reset sp", sp, 0);
    chk("R1", "reset br", br, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset strobes", {mem_rd, mem_wr, done}, 0);

    // Invalid codes never launch (R10)
    for (int c = 6; c < 8; c++) begin
      @(negedge clk); op = 3'(c); start = 1'b1;
      @(negedge clk); start = 1'b0; #1;
      chk("R10", "invalid code busy", busy, 0);
      chk("R10", "invalid code sp", sp, m_sp);
      chk("R11", "invalid code strobes", {mem_rd, mem_wr}, 0);
    end

    // Directed: wrap both ways, upper bits kept
    mem_m[100] = 20'hFFFFF;
    ir_addr = 13'd100;
    run_op(3'd4, 0);
    chk("R8", "load all ones", sp, 13'h1FFF);
    a_reg = 20'h12345;
    run_op(3'd0, 0);
    chk("R8", "push wraps to 0", sp, 0);
    run_op(3'd1, 1);
    chk("R8", "pop wraps to max", sp, 13'h1FFF);
    a_reg = 20'hFE000;
    run_op(3'd0, 0);
    ir_addr = 13'd200;
    run_op(3'd5, 1);
    chk("R7", "upper kept", br[19:13], 7'h7F);
    pc_reg = 13'h0ABC;
    ir_addr = 13'h1111;
    run_op(3'd2, 1);
    chk("R4", "upper kept", br[19:13], 7'h7F);
    run_op(3'd3, 0);
    chk("R5", "return address", pc_reg, 13'h0ABC);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] code;
      code = 3'($urandom_range(0, 5));
      a_reg = 20'($urandom);
      ir_addr = 13'($urandom);
      if ($urandom_range(0, 1) == 1) mem_m[int'(m_sp)] = 20'($urandom);
      if ($urandom_range(0, 1) == 1) mem_m[int'(ir_addr)] = 20'($urandom);
      run_op(code, $urandom_range(0, 1) == 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule